// File: doc/BRIEF.md
# Machine-Mode CSR Register Unit

This unit holds five machine-mode control and status registers of a RISC-V core: the interrupt enable word, the trap vector base, the scratch word, the exception return address and the trap cause. It carries out the six CSR access operations. Each operation overwrites, sets bits in or clears bits in the addressed register. The operand comes either from the rs1 register value or from an immediate that the decode stage has already zero-extended.

When the pipeline signals a trap, the unit captures the program counter as the return address and the supplied cause value. Both are captured in the same cycle, whatever CSR address is presented. The addressed register is always visible on a combinational read port. The enable word, return address and vector base also drive dedicated outputs continuously.

Top module: `mcsr_unit`

## Requirements
- R1: A synchronous reset clears all five registers to zero. Every register then reads zero, and mieOut, mepcOut and mtvecOut are zero.
- R2: The opcodes 3'b001 (rs1 operand) and 3'b101 (immediate operand) replace the addressed register with the operand.
- R3: The opcodes 3'b010 and 3'b110 OR the operand into the addressed register.
- R4: The opcodes 3'b011 and 3'b111 AND the addressed register with the inverted operand.
- R5: Opcode bit 2 selects the operand. A 0 takes rs1Val and a 1 takes immVal, and the operand that is not selected has no effect.
- R6: A register changes only on a rising clock edge with wrEn high and a modifying opcode. With wrEn low, or with opcode 3'b000 or 3'b100, every register holds its value.
- R7: rdData shows the addressed register combinationally, so a value written at an edge is readable in the following cycle. A set with a zero operand reads a register without changing it.
- R8: With trapStrobe high, the next edge loads mepc from pcIn and mcause from causeIn, whatever csrAddr holds.
- R9: A trap takes priority over a CSR write in the same cycle. A write to mepc (0x341) or mcause (0x342) in that cycle is lost. A write to mie (0x304), mtvec (0x305) or mscratch (0x340) in that cycle still takes effect.
- R10: An address other than the five listed reads as zero, and a write to it changes no register.
- R11: mieOut, mepcOut and mtvecOut always equal the current values of mie, mepc and mtvec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| trapStrobe | input | 1 | Trap taken this cycle |
| opCode | input | 3 | CSR operation code |
| csrAddr | input | 12 | CSR address |
| pcIn | input | 32 | Program counter of the trapping instruction |
| causeIn | input | 32 | Trap cause value |
| rs1Val | input | 32 | Register-source operand |
| immVal | input | 32 | Zero-extended immediate operand |
| wrEn | input | 1 | CSR write enable |
| rdData | output | 32 | Value of the addressed register |
| mieOut | output | 32 | Current interrupt enable word |
| mepcOut | output | 32 | Current exception return address |
| mtvecOut | output | 32 | Current trap vector base |

## Verification
The bench hits the unit with a trap and a CSR write in the same cycle. The write targets mepc once and mie once. A design with the priority reversed would leave the written value in mepc, and a design that blocks all writes during a trap would drop the mie update.

The bench presents a modifying opcode with wrEn low, and then the two opcodes that do not modify with wrEn high. A design that decodes the opcode without the enable, or that treats those opcodes as writes, would corrupt the register under test.

Writes to unmapped addresses must read back as zero and leave every register unchanged. A loose address decode would alias them onto a real register. Immediate and register operands are given different values, so a swapped operand select shows up at once.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int NREG = 5;
  localparam int ADDR_W = 12;

  // register slots
  localparam int IDX_MIE = 0;
  localparam int IDX_MTVEC = 1;
  localparam int IDX_MSCRATCH = 2;
  localparam int IDX_MEPC = 3;
  localparam int IDX_MCAUSE = 4;

  typedef enum logic [1:0] {
    MOD_NONE  = 2'b00,
    MOD_WRITE = 2'b01,
    MOD_SET   = 2'b10,
    MOD_CLEAR = 2'b11
  } modKind_e;

  typedef struct packed {
    logic [NREG-1:0] sel;
    logic            wrStb;
    logic            useImm;
    modKind_e        kind;
    logic            trapStb;
  } csrStrobe_t;

  function automatic logic [ADDR_W-1:0] slotAddr(input int idx);
    case (idx)
      IDX_MIE:      slotAddr = 12'h304;
      IDX_MTVEC:    slotAddr = 12'h305;
      IDX_MSCRATCH: slotAddr = 12'h340;
      IDX_MEPC:     slotAddr = 12'h341;
      default:      slotAddr = 12'h342;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
(
  input  logic              trapStrobe,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              wrEn,
  output csrStrobe_t        str
);
  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i] = (csrAddr == slotAddr(i));
  end

  modKind_e kindSel;
  assign kindSel = modKind_e'(opCode[1:0]);

  always_comb begin
    str.sel     = hit;
    str.kind    = kindSel;
    str.useImm  = opCode[2];
    str.wrStb   = wrEn && (kindSel != MOD_NONE);
    str.trapStb = trapStrobe;
  end
endmodule

// File: rtl/mcsr_datapath.sv
module mcsr_datapath
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  csrStrobe_t      str,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] immVal,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] causeIn,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] mieQ,
  output logic [XLEN-1:0] mepcQ,
  output logic [XLEN-1:0] mtvecQ
);
  logic [NREG-1:0][XLEN-1:0] regQ;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] modVal;

  // shared read mux: one-hot select, zero when nothing matches
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREG; i++) begin
      if (str.sel[i]) rdData = rdData | regQ[i];
    end
  end

  assign operand = str.useImm ? immVal : rs1Val;

  // single modify unit works on the addressed value
  always_comb begin
    case (str.kind)
      MOD_WRITE: modVal = operand;
      MOD_SET:   modVal = rdData | operand;
      MOD_CLEAR: modVal = rdData & ~operand;
      default:   modVal = rdData;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit TRAP_SLOT = (i == IDX_MEPC) || (i == IDX_MCAUSE);
    logic [XLEN-1:0] trapVal;
    assign trapVal = (i == IDX_MEPC) ? pcIn : causeIn;

    always_ff @(posedge clk) begin
      if (rst)                          regQ[i] <= '0;
      else if (TRAP_SLOT && str.trapStb) regQ[i] <= trapVal;
      else if (str.wrStb && str.sel[i]) regQ[i] <= modVal;
    end
  end

  assign mieQ   = regQ[IDX_MIE];
  assign mepcQ  = regQ[IDX_MEPC];
  assign mtvecQ = regQ[IDX_MTVEC];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (regQ == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!str.wrStb && !str.trapStb) |=> $stable(regQ));

  // R8
  trap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    str.trapStb |=> (regQ[IDX_MEPC] == $past(pcIn)) && (regQ[IDX_MCAUSE] == $past(causeIn)));

  // R10
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((str.sel == '0) && !str.trapStb) |=> $stable(regQ));
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trapStrobe,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   causeIn,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   immVal,
  input  logic              wrEn,
  output logic [XLEN-1:0]   rdData,
  output logic [XLEN-1:0]   mieOut,
  output logic [XLEN-1:0]   mepcOut,
  output logic [XLEN-1:0]   mtvecOut
);
  csrStrobe_t strobes;

  mcsr_ctrl u_ctrl (
    .trapStrobe(trapStrobe),
    .opCode    (opCode),
    .csrAddr   (csrAddr),
    .wrEn      (wrEn),
    .str       (strobes)
  );

  mcsr_datapath #(.XLEN(XLEN)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .str    (strobes),
    .rs1Val (rs1Val),
    .immVal (immVal),
    .pcIn   (pcIn),
    .causeIn(causeIn),
    .rdData (rdData),
    .mieQ   (mieOut),
    .mepcQ  (mepcOut),
    .mtvecQ (mtvecOut)
  );

  // R11
  mie_port_chk: assert property (@(posedge clk) disable iff (rst)
    (csrAddr == slotAddr(IDX_MIE)) |-> (mieOut == rdData));
endmodule

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        trapStrobe = 0;
  logic [2:0]  opCode = 0;
  logic [11:0] csrAddr = 0;
  logic [31:0] pcIn = 0, causeIn = 0, rs1Val = 0, immVal = 0;
  logic        wrEn = 0;
  logic [31:0] rdData, mieOut, mepcOut, mtvecOut;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdl [5];
  logic [11:0] addrs [5] = '{12'h304, 12'h305, 12'h340, 12'h341, 12'h342};

  mcsr_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int idxOf(input logic [11:0] a);
    for (int i = 0; i < 5; i++) if (addrs[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] modify(input logic [2:0] op, input logic [31:0] cur,
                                         input logic [31:0] r, input logic [31:0] im);
    logic [31:0] v;
    v = op[2] ? im : r;
    case (op[1:0])
      2'b01:   return v;
      2'b10:   return cur | v;
      2'b11:   return cur & ~v;
      default: return cur;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation, issued at a falling edge; the model follows the rising edge
  task automatic doOp(input logic [2:0] op, input logic [11:0] a, input logic [31:0] r,
                      input logic [31:0] im, input logic we, input logic tr,
                      input logic [31:0] pc, input logic [31:0] cause);
    int k;
    @(negedge clk);
    opCode = op; csrAddr = a; rs1Val = r; immVal = im; wrEn = we;
    trapStrobe = tr; pcIn = pc; causeIn = cause;
    @(posedge clk);
    k = idxOf(a);
    if (we && k >= 0 && !(tr && (k == 3 || k == 4))) mdl[k] = modify(op, mdl[k], r, im);
    if (tr) begin mdl[3] = pc; mdl[4] = cause; end
  endtask

  task automatic verifyAll(input string tag);
    @(negedge clk);
    wrEn = 0; trapStrobe = 0; opCode = 3'b010; rs1Val = 0;
    for (int i = 0; i < 5; i++) begin
      csrAddr = addrs[i];
      #1 check(tag, rdData, mdl[i]);
    end
    csrAddr = 12'h7C0;
    #1 check({tag, " R10 unmapped read"}, rdData, 32'h0);
    check({tag, " R11 mie"}, mieOut, mdl[0]);
    check({tag, " R11 mepc"}, mepcOut, mdl[3]);
    check({tag, " R11 mtvec"}, mtvecOut, mdl[1]);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; wrEn = 0; trapStrobe = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    for (int i = 0; i < 5; i++) mdl[i] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    doReset();
    verifyAll("R1 reset");

    doOp(3'b001, 12'h340, 32'hDEADBEEF, 32'h11, 1, 0, 0, 0);
    verifyAll("R2 write rs1");
    doOp(3'b101, 12'h305, 32'hFFFF0000, 32'h0000001F, 1, 0, 0, 0);
    verifyAll("R5 write imm ignores rs1");
    doOp(3'b010, 12'h340, 32'h0000000F, 32'hFFFFFFFF, 1, 0, 0, 0);
    verifyAll("R3 set rs1");
    doOp(3'b111, 12'h340, 32'hFFFFFFFF, 32'h000000F0, 1, 0, 0, 0);
    verifyAll("R4 clear imm");
    doOp(3'b001, 12'h340, 32'h12345678, 0, 0, 0, 0, 0);
    verifyAll("R6 wrEn low");
    doOp(3'b000, 12'h340, 32'h12345678, 32'h1, 1, 0, 0, 0);
    doOp(3'b100, 12'h304, 32'h12345678, 32'h1, 1, 0, 0, 0);
    verifyAll("R6 non-modifying opcodes");
    doOp(3'b010, 12'h340, 32'h0, 32'h55, 1, 0, 0, 0);
    #1 check("R7 read via zero set", rdData, mdl[2]);
    verifyAll("R7 zero set unchanged");
    doOp(3'b001, 12'h304, 32'hA5A5A5A5, 0, 1, 0, 0, 0);
    verifyAll("R7 written value visible");
    doOp(3'b011, 12'h305, 32'h1, 0, 0, 1, 32'h00000400, 32'h8000000B);
    verifyAll("R8 trap any address");
    doOp(3'b001, 12'h341, 32'h77777777, 0, 1, 1, 32'h00000808, 32'h00000002);
    verifyAll("R9 trap beats mepc write");
    doOp(3'b001, 12'h342, 32'h66666666, 0, 1, 1, 32'h00000C0C, 32'h00000003);
    verifyAll("R9 trap beats mcause write");
    doOp(3'b001, 12'h304, 32'h0000FFFF, 0, 1, 1, 32'h00001010, 32'h00000007);
    verifyAll("R9 mie write alongside trap");
    doOp(3'b001, 12'h300, 32'hFFFFFFFF, 0, 1, 0, 0, 0);
    doOp(3'b010, 12'h343, 32'hFFFFFFFF, 0, 1, 0, 0, 0);
    verifyAll("R10 unmapped write");

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      a = ($urandom % 6 == 5) ? 12'($urandom) : addrs[$urandom % 5];
      doOp(3'($urandom), a, $urandom, $urandom % 32, ($urandom % 4) != 0,
           ($urandom % 8) == 0, $urandom, $urandom);
      if (n % 4 == 3) verifyAll("R2 R3 R4 R8 random");
    end

    doReset();
    verifyAll("R1 second reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule